// File: doc/BRIEF.md
# Byte-Wide SPI Master Controller

This block is a memory-mapped SPI master with an 8-bit register file. Software picks the clock polarity, the sampling phase and the bit order, and sets a two-field baud divisor. A byte written to the data register then starts one 8-bit exchange on the serial clock, MOSI and MISO pins. The received byte lands in a read buffer. A completion flag and an interrupt report the end of the exchange.

A small port register pair drives the active-low slave-select pin. A write made while a byte is still shifting is rejected and flagged as a collision. If the slave-select input goes low while the block is a master and is not driving select itself, it reports a mode fault and drops out of master mode. Each flag clears only through a fixed sequence of register accesses.

The register bus completes every access in a single cycle. A read returns data combinationally in the cycle it is presented, and its side effects take hold at the clock edge that ends that cycle.

Top module: `spim_ctrl`

## Requirements
- R1: **Register map and reset values.**
  - Registers sit at these byte offsets: control 0x00, auxiliary control 0x01, baud 0x04, status 0x05, data 0x09, port data 0x0d, port direction 0x10.
  - Control bits: 7 interrupt enable, 6 system enable, 4 master, 3 clock polarity, 2 clock phase, 1 select-output enable, 0 LSB first.
  - After reset every register and flag reads 0, sclk and mosi are low, ss_n_o is high and both interrupts are low.
- R2: **Exchange timing.** The baud register holds a prescale P in bits 6:4 and an exponent E in bits 2:0. Each half period of sclk lasts (P+1)·2^E bus clocks. An exchange is 16 sclk edges, the first coming one half period after the write to the data register.
- R3: **Clock and bit order.**
  - sclk idles at the polarity bit.
  - With phase 0, MISO is sampled on leading edges and MOSI changes on trailing edges. The first bit is on MOSI from the moment of the write.
  - With phase 1, MOSI changes on leading edges and MISO is sampled on trailing edges.
  - Bits go out and come in MSB first, or LSB first when bit 0 is set.
- R4: **Receive buffer.** The byte assembled from MISO is stored in the read buffer on the last sampling edge. A read of the data register returns it.
- R5: **Completion flag.** Status bit 7 sets one bus clock after the 16th sclk edge, that is 16·H+1 clocks after the write edge. It clears only when a status read that sees it set is followed by a data read. A data read without that status read leaves it set.
- R6: **Write collision.**
  - A data write while a byte is shifting sets status bit 6. The byte being shifted is not disturbed, and the written byte is discarded.
  - Bit 6 clears by a status read that sees it set, followed by a data read.
- R7: **Mode fault.**
  - A fault is raised when the system-enable and master bits are set, the select-output enable is clear, and ss_n_i is low after one register stage.
  - The fault sets status bit 4, clears control bits 6 and 4, and aborts any exchange without setting bit 7.
  - With the select-output enable set, a low ss_n_i raises no fault.
- R8: **Fault clear.** Status bit 4 clears only when a status read that sees it set is followed by a write to the control register.
- R9: **Interrupts.** irq_done follows status bit 7 and irq_fault follows status bit 4, each only while the interrupt-enable bit is set.
- R10: **Slave select.** ss_n_o equals bit 3 of port data while bit 3 of port direction is set, and is high otherwise. Writing 0x08 to port data deasserts select and 0x00 asserts it.
- R11: **Disabled state.** With the system-enable bit clear:
  - sclk stays at the polarity level and mosi stays low.
  - A data write starts nothing, sets no flag, and leaves the read buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n_o | output | 1 | Active-low slave select from the port register |
| ss_n_i | input | 1 | Slave-select sense input for fault detection |
| irq_done | output | 1 | Completion interrupt |
| irq_fault | output | 1 | Mode-fault interrupt |

## Verification
The bench builds the block with its default address width of 5 bits, which the 0x10 direction offset needs. The divisor is a run-time field rather than a build parameter, so the bench programs baud values from the smallest half period of one clock up to the largest of 1024 clocks. This brings the exact 16·H+1 completion latency into reach at both ends and at prescale values that are not powers of two. All four polarity and phase combinations are exercised with both bit orders against a slave model that counts edges by itself.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int FRAME_BITS = 8;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int PRE_W      = 3;
    localparam int EXP_W      = 3;
    // widest half-period reload value: (2^PRE_W) * 2^(2^EXP_W - 1) - 1
    localparam int CNT_W      = PRE_W + (2 ** EXP_W) - 1;

    // register offsets
    localparam int A_CTL1 = 'h00;
    localparam int A_CTL2 = 'h01;
    localparam int A_BAUD = 'h04;
    localparam int A_STAT = 'h05;
    localparam int A_DATA = 'h09;
    localparam int A_PDAT = 'h0D;
    localparam int A_PDIR = 'h10;

    // control bit positions
    localparam int C_IE   = 7;
    localparam int C_EN   = 6;
    localparam int C_MST  = 4;
    localparam int C_POL  = 3;
    localparam int C_PHA  = 2;
    localparam int C_SSOE = 1;
    localparam int C_LSB  = 0;

    // status bit positions
    localparam int S_DONE = 7;
    localparam int S_COL  = 6;
    localparam int S_FLT  = 4;

    // port bit that drives slave select
    localparam int P_SS   = 3;

    typedef logic [FRAME_BITS-1:0] byte_t;

    typedef struct packed {
        logic pol;
        logic pha;
        logic lsb;
    } shift_cfg_t;

    // bus clocks per half sclk period, minus one
    function automatic logic [CNT_W-1:0] reload_val(logic [PRE_W-1:0] p, logic [EXP_W-1:0] e);
        logic [CNT_W:0] h;
        logic [CNT_W:0] t;
        h = (CNT_W+1)'(p) + (CNT_W+1)'(1);
        h = h << e;
        t = h - (CNT_W+1)'(1);
        return t[CNT_W-1:0];
    endfunction

    // wire position of the i-th bit on the line
    function automatic logic [IDX_W-1:0] bit_pos(logic lsb_first, logic [IDX_W-1:0] i);
        return lsb_first ? i : IDX_W'(FRAME_BITS - 1) - i;
    endfunction

endpackage

// File: rtl/spim_baud.sv
module spim_baud
    import spim_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PRE_W-1:0] pre,
    input  logic [EXP_W-1:0] expo,
    output logic             tick
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (!run || cnt_q == '0)
            cnt_q <= reload_val(pre, expo);
        else
            cnt_q <= cnt_q - 1'b1;
    end

    assign tick = run && (cnt_q == '0);

endmodule

// File: rtl/spim_shift.sv
module spim_shift
    import spim_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       abort,
    input  logic       tick,
    input  logic       miso,
    input  byte_t      tx_byte,
    input  shift_cfg_t cfg,
    output logic       sclk,
    output logic       mosi,
    output logic       busy,
    output logic       done,
    output logic       rx_load,
    output byte_t      rx_next
);

    localparam int EDGE_W = $clog2(2 * FRAME_BITS);

    logic [EDGE_W-1:0] edge_q;
    logic              phase_q, mosi_q, busy_q, done_q;
    byte_t             tx_q, rx_q;
    shift_cfg_t        cfg_q;

    logic [IDX_W-1:0]  idx;
    logic              leading, sample, last;

    assign idx     = edge_q[EDGE_W-1:1];
    assign leading = ~edge_q[0];
    assign sample  = cfg_q.pha ? ~leading : leading;
    assign last    = (edge_q == EDGE_W'(2 * FRAME_BITS - 1));

    always_comb begin
        rx_next = rx_q;
        rx_next[bit_pos(cfg_q.lsb, idx)] = miso;
    end

    assign rx_load = busy_q && tick && sample && (idx == IDX_W'(FRAME_BITS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_q  <= '0;
            phase_q <= 1'b0;
            mosi_q  <= 1'b0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            tx_q    <= '0;
            rx_q    <= '0;
            cfg_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (abort) begin
                busy_q  <= 1'b0;
                phase_q <= 1'b0;
            end else if (start && !busy_q) begin
                busy_q  <= 1'b1;
                edge_q  <= '0;
                phase_q <= 1'b0;
                tx_q    <= tx_byte;
                cfg_q   <= cfg;
                rx_q    <= '0;
                mosi_q  <= tx_byte[bit_pos(cfg.lsb, IDX_W'(0))];
            end else if (busy_q && tick) begin
                phase_q <= ~phase_q;
                edge_q  <= edge_q + 1'b1;
                if (sample)
                    rx_q <= rx_next;
                if (!cfg_q.pha && !leading && !last)
                    mosi_q <= tx_q[bit_pos(cfg_q.lsb, IDX_W'(idx + 1'b1))];
                if (cfg_q.pha && leading)
                    mosi_q <= tx_q[bit_pos(cfg_q.lsb, idx)];
                if (last) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign sclk = busy_q ? (cfg_q.pol ^ phase_q) : cfg.pol;
    assign mosi = busy_q & mosi_q;
    assign busy = busy_q;
    assign done = done_q;

endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
    import spim_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              ss_n_o,
    input  logic              ss_n_i,
    output logic              irq_done,
    output logic              irq_fault
);

    byte_t ctl_q, ctl2_q, baud_q, pdat_q, pdir_q, rdbuf_q;
    logic  done_q, col_q, flt_q;
    logic  done_arm_q, col_arm_q, flt_arm_q;
    logic  ss_sync_q;

    logic wr, rd;
    logic hit_ctl1, hit_ctl2, hit_baud, hit_stat, hit_data, hit_pdat, hit_pdir;
    logic en, mst, fault_now, start, collide, abort;
    logic sh_busy, sh_done, sh_rx_load, tick;
    byte_t sh_rx_next;
    shift_cfg_t cfg;

    assign wr = bus_sel & bus_we;
    assign rd = bus_sel & ~bus_we;

    assign hit_ctl1 = (bus_addr == ADDR_W'(A_CTL1));
    assign hit_ctl2 = (bus_addr == ADDR_W'(A_CTL2));
    assign hit_baud = (bus_addr == ADDR_W'(A_BAUD));
    assign hit_stat = (bus_addr == ADDR_W'(A_STAT));
    assign hit_data = (bus_addr == ADDR_W'(A_DATA));
    assign hit_pdat = (bus_addr == ADDR_W'(A_PDAT));
    assign hit_pdir = (bus_addr == ADDR_W'(A_PDIR));

    assign en        = ctl_q[C_EN];
    assign mst       = ctl_q[C_MST];
    assign fault_now = en & mst & ~ctl_q[C_SSOE] & ~ss_sync_q;
    assign start     = wr & hit_data & en & mst & ~sh_busy & ~fault_now;
    assign collide   = wr & hit_data & en & mst & sh_busy;
    assign abort     = fault_now | (wr & hit_ctl1 & ~(bus_wdata[C_EN] & bus_wdata[C_MST]));

    assign cfg.pol = ctl_q[C_POL];
    assign cfg.pha = ctl_q[C_PHA];
    assign cfg.lsb = ctl_q[C_LSB];

    spim_baud u_baud (
        .clk  (clk),
        .rst  (rst),
        .run  (sh_busy),
        .pre  (baud_q[4 +: PRE_W]),
        .expo (baud_q[0 +: EXP_W]),
        .tick (tick)
    );

    spim_shift u_shift (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .abort   (abort),
        .tick    (tick),
        .miso    (miso),
        .tx_byte (bus_wdata),
        .cfg     (cfg),
        .sclk    (sclk),
        .mosi    (mosi),
        .busy    (sh_busy),
        .done    (sh_done),
        .rx_load (sh_rx_load),
        .rx_next (sh_rx_next)
    );

    // register file
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q     <= '0;
            ctl2_q    <= '0;
            baud_q    <= '0;
            pdat_q    <= '0;
            pdir_q    <= '0;
            rdbuf_q   <= '0;
            ss_sync_q <= 1'b1;
        end else begin
            ss_sync_q <= ss_n_i;
            if (fault_now) begin
                ctl_q[C_EN]  <= 1'b0;
                ctl_q[C_MST] <= 1'b0;
            end else if (wr && hit_ctl1) begin
                ctl_q <= bus_wdata;
            end
            if (wr && hit_ctl2) ctl2_q <= bus_wdata;
            if (wr && hit_baud) baud_q <= bus_wdata;
            if (wr && hit_pdat) pdat_q <= bus_wdata;
            if (wr && hit_pdir) pdir_q <= bus_wdata;
            if (sh_rx_load)     rdbuf_q <= sh_rx_next;
        end
    end

    // flags: setting wins and drops the arm; a flagged status read arms the clear
    always_ff @(posedge clk) begin
        if (rst) begin
            done_q     <= 1'b0;
            col_q      <= 1'b0;
            flt_q      <= 1'b0;
            done_arm_q <= 1'b0;
            col_arm_q  <= 1'b0;
            flt_arm_q  <= 1'b0;
        end else begin
            if (sh_done) begin
                done_q     <= 1'b1;
                done_arm_q <= 1'b0;
            end else if (rd && hit_data && done_arm_q) begin
                done_q     <= 1'b0;
                done_arm_q <= 1'b0;
            end else if (rd && hit_stat && done_q) begin
                done_arm_q <= 1'b1;
            end

            if (collide) begin
                col_q     <= 1'b1;
                col_arm_q <= 1'b0;
            end else if (rd && hit_data && col_arm_q) begin
                col_q     <= 1'b0;
                col_arm_q <= 1'b0;
            end else if (rd && hit_stat && col_q) begin
                col_arm_q <= 1'b1;
            end

            if (fault_now) begin
                flt_q     <= 1'b1;
                flt_arm_q <= 1'b0;
            end else if (wr && hit_ctl1 && flt_arm_q) begin
                flt_q     <= 1'b0;
                flt_arm_q <= 1'b0;
            end else if (rd && hit_stat && flt_q) begin
                flt_arm_q <= 1'b1;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(A_CTL1): bus_rdata = ctl_q;
            ADDR_W'(A_CTL2): bus_rdata = ctl2_q;
            ADDR_W'(A_BAUD): bus_rdata = baud_q;
            ADDR_W'(A_STAT): begin
                bus_rdata[S_DONE] = done_q;
                bus_rdata[S_COL]  = col_q;
                bus_rdata[S_FLT]  = flt_q;
            end
            ADDR_W'(A_DATA): bus_rdata = rdbuf_q;
            ADDR_W'(A_PDAT): bus_rdata = pdat_q;
            ADDR_W'(A_PDIR): bus_rdata = pdir_q;
            default:         bus_rdata = '0;
        endcase
    end

    assign ss_n_o    = pdir_q[P_SS] ? pdat_q[P_SS] : 1'b1;
    assign irq_done  = ctl_q[C_IE] & done_q;
    assign irq_fault = ctl_q[C_IE] & flt_q;

endmodule

// File: rtl/spim_ctrl_chk.sv
module spim_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic sclk,
    input logic mosi,
    input logic pol,
    input logic en,
    input logic done_f,
    input logic col_f,
    input logic flt_f
);

    // R2
    sclk_idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(busy) && $stable(pol)) |-> $stable(sclk));

    // R5
    done_after_shift_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_f) |-> ($past(busy, 2) && !$past(busy)));

    // R6
    col_only_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(col_f) |-> $past(busy));

    // R7
    fault_aborts_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flt_f) |-> !busy);

    // R11
    disabled_lines_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !en |-> (sclk == pol && !mosi && !busy));

endmodule

bind spim_ctrl spim_ctrl_chk chk_i (
    .clk    (clk),
    .rst    (rst),
    .busy   (sh_busy),
    .sclk   (sclk),
    .mosi   (mosi),
    .pol    (ctl_q[3]),
    .en     (ctl_q[6]),
    .done_f (done_q),
    .col_f  (col_q),
    .flt_f  (flt_q)
);

// File: tb/spim_ctrl_tb_top.sv
module spim_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_we = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sclk, mosi, ss_n_o, irq_done, irq_fault;
    logic       miso = 1'b0;
    logic       ss_n_i = 1'b1;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    spim_ctrl #(.ADDR_W(5)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sclk      (sclk),
        .mosi      (mosi),
        .miso      (miso),
        .ss_n_o    (ss_n_o),
        .ss_n_i    (ss_n_i),
        .irq_done  (irq_done),
        .irq_fault (irq_fault)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // slave model and scoreboard
    logic       slv_active = 1'b0;
    logic       s_pol = 1'b0, s_pha = 1'b0, s_lsb = 1'b0;
    logic [7:0] s_tx = '0, s_cap = '0;
    int         s_cnt = 0, s_drv = 0;
    logic       lead;
    event       frame_ev;
    logic [7:0] exp_q[$];

    function automatic int bp(input logic l, input int i);
        return l ? i : 7 - i;
    endfunction

    task automatic slave_prep(input logic pol, input logic pha, input logic lsb, input logic [7:0] tx);
        s_pol = pol; s_pha = pha; s_lsb = lsb; s_tx = tx;
        s_cap = '0; s_cnt = 0;
        if (!pha) begin
            miso = tx[bp(lsb, 0)];
            s_drv = 1;
        end else begin
            s_drv = 0;
        end
        slv_active = 1'b1;
    endtask

    always @(sclk) begin
        if (slv_active) begin
            lead = (sclk != s_pol);
            if (s_pha ? !lead : lead) begin
                s_cap[bp(s_lsb, s_cnt)] = mosi;
                s_cnt++;
                if (s_cnt == 8) begin
                    slv_active = 1'b0;
                    ->frame_ev;
                end
            end else if (s_drv < 8) begin
                miso = s_tx[bp(s_lsb, s_drv)];
                s_drv++;
            end
        end
    end

    initial begin
        logic [7:0] e;
        forever begin
            @(frame_ev);
            if (exp_q.size() == 0) begin
                check("R3 unexpected frame", 32'(s_cap), 32'hFFFF_FFFF);
            end else begin
                e = exp_q.pop_front();
                // R3: MOSI byte as seen by the slave on its sampling edges
                check("R3 mosi frame", 32'(s_cap), 32'(e));
            end
        end
    end

    task automatic wait_irq(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!irq_done && n < 20000);
    endtask

    logic [7:0] last_rx = '0;

    task automatic xfer(input logic pol, input logic pha, input logic lsb,
                        input int p, input int ex, input logic [7:0] tx, input logic [7:0] srx);
        logic [7:0] d;
        int n;
        wr(5'h00, 8'hD0 | {4'b0, pol, pha, 1'b0, lsb});
        wr(5'h04, 8'((p << 4) | ex));
        slave_prep(pol, pha, lsb, srx);
        exp_q.push_back(tx);
        wr(5'h09, tx);
        wait_irq(n);
        // R2 / R5: completion latency 16*H+1 after the write edge
        check("R2 R5 latency", 32'(n), 32'(16 * ((p + 1) << ex) + 1));
        check("R3 sclk idle", 32'(sclk), 32'(pol));
        rd(5'h05, d);
        check("R5 status done", 32'(d), 32'h80);
        rd(5'h09, d);
        // R4: received byte
        check("R4 rx byte", 32'(d), 32'(srx));
        last_rx = srx;
        check("R5 cleared irq", 32'(irq_done), 32'h0);
        rd(5'h05, d);
        check("R5 status cleared", 32'(d), 32'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1..all actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int n, tog;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(5'h00, d); check("R1 ctl reset", 32'(d), 32'h00);
        rd(5'h05, d); check("R1 status reset", 32'(d), 32'h00);
        rd(5'h04, d); check("R1 baud reset", 32'(d), 32'h00);
        rd(5'h09, d); check("R1 data reset", 32'(d), 32'h00);
        check("R1 lines", 32'({sclk, mosi, ss_n_o, irq_done, irq_fault}), 32'b00100);
        wr(5'h01, 8'h5A); rd(5'h01, d); check("R1 aux ctl", 32'(d), 32'h5A);

        // R10 slave select port
        wr(5'h0D, 8'h08); wr(5'h10, 8'h08);
        check("R10 deassert", 32'(ss_n_o), 32'h1);
        wr(5'h0D, 8'h00);
        check("R10 assert", 32'(ss_n_o), 32'h0);
        wr(5'h10, 8'h00);
        check("R10 dir off", 32'(ss_n_o), 32'h1);
        wr(5'h10, 8'h08);
        rd(5'h10, d); check("R10 dir readback", 32'(d), 32'h08);

        // R2 R3 R4 R5 across modes and divisors
        xfer(0, 0, 0, 0, 0, 8'hA5, 8'h3C);
        xfer(0, 1, 0, 1, 1, 8'h5A, 8'hC3);
        xfer(1, 0, 1, 2, 0, 8'h81, 8'h7E);
        xfer(1, 1, 1, 0, 2, 8'h0F, 8'hF0);
        xfer(0, 0, 1, 7, 0, 8'h96, 8'h2B);
        xfer(1, 0, 0, 7, 7, 8'h33, 8'hCC);

        // R6 collision
        wr(5'h00, 8'hD0); wr(5'h04, 8'h11);
        slave_prep(0, 0, 0, 8'h11);
        exp_q.push_back(8'h3C);
        wr(5'h09, 8'h3C);
        repeat (5) @(negedge clk);
        wr(5'h09, 8'hFF);
        wait_irq(n);
        rd(5'h05, d); check("R6 col and done", 32'(d), 32'hC0);
        rd(5'h09, d); check("R6 rx intact", 32'(d), 32'h11);
        rd(5'h05, d); check("R6 flags cleared", 32'(d), 32'h00);
        last_rx = 8'h11;

        // R5 data read without status read keeps the flag; R9 gating
        wr(5'h00, 8'h50); wr(5'h04, 8'h00);
        slave_prep(0, 0, 0, 8'h42);
        exp_q.push_back(8'h24);
        wr(5'h09, 8'h24);
        repeat (30) @(negedge clk);
        check("R9 irq gated off", 32'(irq_done), 32'h0);
        rd(5'h09, d);
        rd(5'h05, d); check("R5 flag kept", 32'(d), 32'h80);
        rd(5'h09, d); check("R4 rx gated run", 32'(d), 32'h42);
        rd(5'h05, d); check("R5 flag now clear", 32'(d), 32'h00);
        last_rx = 8'h42;

        // R11 disabled
        wr(5'h00, 8'h08);
        check("R11 sclk idle", 32'(sclk), 32'h1);
        check("R11 mosi low", 32'(mosi), 32'h0);
        tog = 0;
        wr(5'h09, 8'h55);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sclk !== 1'b1) tog++;
        end
        check("R11 no clocks", 32'(tog), 32'h0);
        rd(5'h05, d); check("R11 no flags", 32'(d), 32'h00);
        rd(5'h09, d); check("R11 buffer kept", 32'(d), 32'(last_rx));

        // R7 no fault when driving select
        ss_n_i = 1'b0;
        wr(5'h00, 8'h52);
        repeat (4) @(negedge clk);
        rd(5'h05, d); check("R7 ssoe masks fault", 32'(d), 32'h00);
        ss_n_i = 1'b1;

        // R7 fault aborts an exchange
        wr(5'h00, 8'hD0); wr(5'h04, 8'h11);
        wr(5'h09, 8'h77);
        repeat (10) @(negedge clk);
        ss_n_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 irq_fault", 32'(irq_fault), 32'h1);
        check("R7 sclk idle", 32'(sclk), 32'h0);
        check("R7 mosi low", 32'(mosi), 32'h0);
        rd(5'h00, d); check("R7 ctl bits cleared", 32'(d), 32'h80);
        ss_n_i = 1'b1;
        // R8 write alone does not clear
        wr(5'h00, 8'h80);
        check("R8 fault held", 32'(irq_fault), 32'h1);
        rd(5'h05, d); check("R7 status fault", 32'(d), 32'h10);
        repeat (100) @(negedge clk);
        rd(5'h05, d); check("R7 no done after abort", 32'(d), 32'h10);
        wr(5'h00, 8'h80);
        rd(5'h05, d); check("R8 fault cleared", 32'(d), 32'h00);
        check("R8 irq released", 32'(irq_fault), 32'h0);

        check("R3 scoreboard drained", 32'(exp_q.size()), 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule